// File: doc/BRIEF.md
# SMBus Slave Control Register Bank

This block is a two-wire slave that lets a host read and write a small bank of 8-bit control registers. It samples SCL and SDA, which arrive already synchronised to the system clock. It finds START, repeated START and STOP conditions, matches a 7-bit device address and answers each byte with an acknowledge. The slave drives SDA only by pulling it low, through `sda_oe`. The pad or the bench combines this with the other devices on the wire to form the open-drain line.

After the address with the write bit, the host sends a command code. Bit 7 of the command picks the transfer style. When it is 1 the transfer is a single-byte access. When it is 0 the transfer is a block access, in which a byte count comes first. Bits 6:0 of the command give the first register index. A read uses the same command, sent in a write phase, then a repeated START and the address with the read bit set.

Register 0 holds five active-high channel-enable bits, which are exported on `chan_en`. All five come out of reset enabled.

Top module: `smb_regbank`

## Requirements
- R1: After reset, register 0 holds 0x7C, every other register holds 0x00, and `chan_en` is 5'b11111.
- R2: The slave acknowledges an address byte whose bits 7:1 equal the `DEV_ADDR` parameter (default 0x69), where bit 0 is 0 for write and 1 for read. For any other address it does not acknowledge, it leaves SDA released, and the rest of that transaction has no effect until the next START or STOP.
- R3: In a byte write (command bit 7 = 1), the one data byte is stored in register `cmd[6:0]`, and the slave acknowledges the address, command and data bytes.
- R4: In a byte read (command bit 7 = 1), the slave returns register `cmd[6:0]` after the repeated START and read address, most significant bit first.
- R5: In a block write (command bit 7 = 0), the first byte after the command is a count. It is acknowledged and not stored. Each byte after it goes to consecutive registers, starting at `cmd[6:0]`.
- R6: A block read (command bit 7 = 0) first returns a count byte equal to `NUM_REGS` (default 4). It then returns registers from `cmd[6:0]` upward while the host acknowledges. The host's NOT-acknowledge ends the transfer, and the slave releases SDA.
- R7: A write to an index at or above `NUM_REGS` is acknowledged and discarded. A read from such an index returns 0x00.
- R8: Bit 7 of register 0 always reads 0 and ignores writes. Bits 1:0 of register 0 are plain read/write storage.
- R9: A START or STOP in the middle of a byte aborts the transfer. A STOP returns the slave to idle, and a START returns it to address reception. A partly received byte is never written.
- R10: The slave begins pulling SDA low only while SCL is low.
- R11: `chan_en[i]` equals bit i+2 of register 0, for i = 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level, as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| chan_en | output | 5 | Channel enables taken from register 0 bits 6:2 |

## Verification
The bench first applies a table of byte writes, each followed by a byte read, with data patterns that are not bit-palindromes. A bit-order fault therefore shows up as a wrong value rather than a match. Writing 0xFF and then 0x01 to register 0 separates the reserved bit, the two plain storage bits and the five exported enables. Block transfers that start at a non-zero index show whether the count byte is skipped on writes, whether it is emitted on reads, and whether the index auto-increments. Starting one such transfer near the top of the bank also exercises the discard of out-of-range writes. A wrong device address, a STOP in the middle of a byte and a START in the middle of a byte each distinguish a true abort from a partial write.

// File: rtl/smb_pkg.sv
package smb_pkg;

  localparam int BYTE_W = 8;
  localparam int BITS_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } smb_state_e;

endpackage

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  // Previous levels; the idle bus is high on both wires.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    scl_rise  = !scl_q && scl_i;
    scl_fall  = scl_q && !scl_i;
    start_det = scl_q && scl_i && sda_q && !sda_i;
    stop_det  = scl_q && scl_i && !sda_q && sda_i;
  end

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [smb_pkg::BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [smb_pkg::BYTE_W-1:0] rd_data,
  output logic [smb_pkg::BYTE_W-1:0] reg0_q
);
  import smb_pkg::*;

  localparam int            SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_d;
  logic [NUM_REGS-1:0]             hit;

  function automatic logic [BYTE_W-1:0] reset_value(input int idx);
    return (idx == 0) ? 8'h7C : 8'h00;
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    // Register 0 keeps its top bit at zero; the others are fully writable.
    localparam logic [BYTE_W-1:0] WMASK = (g == 0) ? 8'h7F : 8'hFF;
    assign hit[g]    = wr_en && (wr_idx == IDX_W'(g));
    assign regs_d[g] = hit[g] ? (wr_data & WMASK) : regs_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reset_value(i);
    end else if (wr_en) begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    if (rd_idx < LIMIT) rd_data = regs_q[rd_idx[SEL_W-1:0]];
    else                rd_data = '0;
  end

  assign reg0_q = regs_q[0];

  AST_RSVD_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_q[0][7]);                                                   // R8
  AST_OOR_WRITE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx >= LIMIT)) |=> $stable(regs_q));                // R7

endmodule

// File: rtl/smb_slave_fsm.sv
module smb_slave_fsm #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 4,
  parameter int         IDX_W    = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       start_det,
  input  logic                       stop_det,
  input  logic [smb_pkg::BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]           rd_idx,
  output logic                       wr_en,
  output logic [IDX_W-1:0]           wr_idx,
  output logic [smb_pkg::BYTE_W-1:0] wr_data,
  output logic                       sda_oe
);
  import smb_pkg::*;

  localparam logic [BITS_W-1:0] FULL  = BITS_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] COUNT = BYTE_W'(NUM_REGS);
  localparam logic [IDX_W-1:0]  PMAX  = '1;

  smb_state_e          state_q, state_d;
  logic [BITS_W-1:0]   bits_q, bits_d;
  logic [BYTE_W-1:0]   rx_q, rx_d;
  logic [BYTE_W-1:0]   tx_q, tx_d;
  logic [IDX_W-1:0]    ptr_q, ptr_d;
  logic                blk_q, blk_d;
  logic                first_q, first_d;
  logic                rw_q, rw_d;
  logic                mack_q, mack_d;
  logic [IDX_W-1:0]    ptr_inc;

  assign ptr_inc = (ptr_q == PMAX) ? ptr_q : ptr_q + 1'b1;

  always_comb begin
    state_d = state_q;
    bits_d  = bits_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    blk_d   = blk_q;
    first_d = first_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
    end else if (start_det) begin
      state_d = ST_ADDR;
      bits_d  = '0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && (bits_q < FULL)) begin
            rx_d   = {rx_q[BYTE_W-2:0], sda_i};
            bits_d = bits_q + 1'b1;
          end else if (scl_fall && (bits_q == FULL)) begin
            bits_d = '0;
            if (state_q == ST_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                state_d = ST_ADDR_ACK;
                rw_d    = rx_q[0];
              end else begin
                state_d = ST_IGNORE;
              end
            end else if (state_q == ST_CMD) begin
              state_d = ST_CMD_ACK;
              ptr_d   = IDX_W'(rx_q[6:0]);
              blk_d   = !rx_q[7];
              first_d = !rx_q[7];
            end else begin
              state_d = ST_WDATA_ACK;
              if (first_q) begin
                first_d = 1'b0;
              end else begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_RDATA;
              bits_d  = '0;
              if (blk_q && first_q) begin
                tx_d    = COUNT;
                first_d = 1'b0;
              end else begin
                tx_d  = rd_data;
                ptr_d = ptr_inc;
              end
            end else begin
              state_d = ST_CMD;
            end
          end
        end
        ST_CMD_ACK, ST_WDATA_ACK: begin
          if (scl_fall) state_d = ST_WDATA;
        end
        ST_RDATA: begin
          if (scl_rise && (bits_q < FULL)) begin
            bits_d = bits_q + 1'b1;
          end else if (scl_fall) begin
            if (bits_q == FULL) begin
              state_d = ST_RDATA_ACK;
              bits_d  = '0;
            end else begin
              tx_d = {tx_q[BYTE_W-2:0], 1'b0};
            end
          end
        end
        ST_RDATA_ACK: begin
          if (scl_rise) begin
            mack_d = !sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              tx_d    = rd_data;
              ptr_d   = ptr_inc;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      blk_q   <= 1'b0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      blk_q   <= blk_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign rd_idx  = ptr_q;
  assign wr_idx  = ptr_q;
  assign wr_data = rx_q;

  always_comb begin
    unique case (state_q)
      ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
      ST_RDATA:                              sda_oe = !tx_q[BYTE_W-1];
      default:                               sda_oe = 1'b0;
    endcase
  end

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);                                        // R10
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE));                               // R9
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR));               // R9
  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_oe);                              // R2

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [4:0] chan_en
);
  import smb_pkg::*;

  localparam int IDX_W  = 7;
  localparam int CH_LSB = 2;
  localparam int CH_N   = 5;

  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data, reg0_q;

  smb_bus_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_slave_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  smb_regfile #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .reg0_q  (reg0_q)
  );

  assign chan_en = reg0_q[CH_LSB +: CH_N];                            // R11

endmodule

// File: tb/smb_regbank_tb_top.sv
module smb_regbank_tb_top;

  localparam logic [6:0] ADDR = 7'h69;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [4:0] chan_en;
  int total = 0;
  int bad = 0;
  int glitches = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  smb_regbank dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .sda_oe  (sda_oe),
    .chan_en (chan_en)
  );

  // R10 monitor: the slave must not start pulling while SCL is high
  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) glitches++;
    oe_prev <= sda_oe;
  end

  // {is_read, command, data, expected}; write rows expect chan_en
  localparam logic [24:0] VEC [10] = '{
    {1'b0, 8'h81, 8'hA6, 8'h1F},
    {1'b1, 8'h81, 8'h00, 8'hA6},
    {1'b0, 8'h82, 8'h1D, 8'h1F},
    {1'b1, 8'h82, 8'h00, 8'h1D},
    {1'b0, 8'h80, 8'hFF, 8'h1F},
    {1'b1, 8'h80, 8'h00, 8'h7F},
    {1'b0, 8'h80, 8'h01, 8'h00},
    {1'b1, 8'h80, 8'h00, 8'h01},
    {1'b0, 8'h83, 8'hC8, 8'h00},
    {1'b1, 8'h83, 8'h00, 8'hC8}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;    tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    ack = ~sda_bus; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(4);
      scl_m = 1'b1; tick(4);
      b[i] = sda_bus; tick(4);
      scl_m = 1'b0; tick(4);
    end
    put_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  task automatic byte_write(input logic [7:0] cmd, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(cmd, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_read(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    bus_start();
    send_byte({ADDR, 1'b0}, a0);
    send_byte(cmd, a1);
    bus_start();
    send_byte({ADDR, 1'b1}, a2);
    recv_byte(1'b0, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic block_write(input logic [7:0] cmd, input logic [31:0] bytes,
                             input int n, output logic ok);
    logic a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); ok = a;
    send_byte(cmd, a); ok &= a;
    send_byte(8'(n), a); ok &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(bytes[31-8*i -: 8], a);
      ok &= a;
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok;
    logic [7:0] d;
    logic [7:0] cnt;
    logic [7:0] blk [4];
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 / R11: reset state
    check("R1 R11 chan_en after reset", {3'b0, chan_en}, 8'h1F);
    check("R1 sda released after reset", {7'b0, sda_oe}, 8'h00);
    byte_read(8'h80, d, ok);
    check("R1 reg0 reset value", d, 8'h7C);
    byte_read(8'h81, d, ok);
    check("R1 reg1 reset value", d, 8'h00);

    // R3 / R4 / R8 / R11: table of byte writes and reads
    for (int v = 0; v < 10; v++) begin
      if (VEC[v][24]) begin
        byte_read(VEC[v][23:16], d, ok);
        check("R4 R8 byte read data", d, VEC[v][7:0]);
        check("R4 byte read acks", {7'b0, ok}, 8'h01);
      end else begin
        byte_write(VEC[v][23:16], VEC[v][15:8], ok);
        check("R3 byte write acks", {7'b0, ok}, 8'h01);
        check("R11 chan_en after write", {3'b0, chan_en}, VEC[v][7:0]);
      end
    end

    // R2: wrong address is not acknowledged and its writes are ignored
    begin
      logic a0, a1;
      bus_start();
      send_byte({7'h68, 1'b0}, a0);
      send_byte(8'h80, a1);
      send_byte(8'h7C, a1);
      bus_stop();
      check("R2 mismatch no ack", {7'b0, a0}, 8'h00);
      byte_read(8'h80, d, ok);
      check("R2 mismatch write ignored", d, 8'h01);
    end

    // R5: block write of three bytes from register 1
    block_write(8'h01, 32'h11223300, 3, ok);
    check("R5 block write acks", {7'b0, ok}, 8'h01);

    // R6: block read from register 0: count then four data bytes
    begin
      logic a0, a1, a2;
      bus_start();
      send_byte({ADDR, 1'b0}, a0);
      send_byte(8'h00, a1);
      bus_start();
      send_byte({ADDR, 1'b1}, a2);
      recv_byte(1'b1, cnt);
      recv_byte(1'b1, blk[0]);
      recv_byte(1'b1, blk[1]);
      recv_byte(1'b1, blk[2]);
      recv_byte(1'b0, blk[3]);
      check("R6 sda released after nack", {7'b0, sda_bus}, 8'h01);
      bus_stop();
      check("R6 block read count", cnt, 8'h04);
      check("R6 block read reg0", blk[0], 8'h01);
      check("R5 R6 block data reg1", blk[1], 8'h11);
      check("R5 R6 block data reg2", blk[2], 8'h22);
      check("R5 R6 block data reg3", blk[3], 8'h33);
    end

    // R7: out-of-range access
    byte_write(8'h85, 8'h77, ok);
    check("R7 out-of-range write acked", {7'b0, ok}, 8'h01);
    byte_read(8'h85, d, ok);
    check("R7 out-of-range read zero", d, 8'h00);
    block_write(8'h02, 32'h44556600, 3, ok);
    check("R7 block overrun acked", {7'b0, ok}, 8'h01);
    byte_read(8'h82, d, ok);
    check("R5 R7 reg2 after overrun", d, 8'h44);
    byte_read(8'h83, d, ok);
    check("R5 R7 reg3 after overrun", d, 8'h55);
    byte_read(8'h80, d, ok);
    check("R7 reg0 untouched by overrun", d, 8'h01);

    // R9: STOP in the middle of a data byte
    begin
      logic a0, a1;
      bus_start();
      send_byte({ADDR, 1'b0}, a0);
      send_byte(8'h81, a1);
      put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
      bus_stop();
      byte_read(8'h81, d, ok);
      check("R9 stop abort keeps reg1", d, 8'h11);
    end

    // R9: repeated START in the middle of a data byte, then a full write
    begin
      logic a0, a1, a2, a3, a4;
      bus_start();
      send_byte({ADDR, 1'b0}, a0);
      send_byte(8'h82, a1);
      put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
      bus_start();
      send_byte({ADDR, 1'b0}, a2);
      send_byte(8'h83, a3);
      send_byte(8'h99, a4);
      bus_stop();
      check("R9 restart address acked", {7'b0, a2}, 8'h01);
      byte_read(8'h82, d, ok);
      check("R9 start abort keeps reg2", d, 8'h44);
      byte_read(8'h83, d, ok);
      check("R9 write after restart", d, 8'h99);
    end

    // R8: plain bits 1:0 and reserved bit 7 of register 0
    byte_write(8'h80, 8'h82, ok);
    byte_read(8'h80, d, ok);
    check("R8 reserved ignored, bit1 stored", d, 8'h02);
    check("R11 chan_en all off", {3'b0, chan_en}, 8'h00);

    // R10: bus timing of every slave pull
    check("R10 pulls started with SCL low", 8'(glitches), 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule